// File: doc/BRIEF.md
# SMBus Bus Timeout Monitor

This block watches the synchronised clock and data lines of an SMBus port and detects two line conditions. The first is a stuck bus: the clock line held low for too long. A 16-bit counter is loaded from a programmable start value and counts one step per system clock while the clock line is low. When it wraps past all ones, it sets a sticky low-timeout interrupt flag. Software then recovers the port by disabling and re-enabling it.

The second condition is an idle bus. When this detection is enabled, a small counter counts ticks of the SMBus clock source while both lines are high. When both lines have stayed high for more than the configured number of ticks, the block issues a one-cycle event. The surrounding port controller treats this event as a detected STOP: it raises its interrupt and sets its STOP flag.

Each detector has its own enable. Recovery actions are outside this block.

Top module: `smbus_timeout_mon`

## Requirements
- R1: While low-timeout detection is enabled and SCL is high, the timeout counter is held at the reload value every cycle. A low interval that ends before overflow therefore leaves no trace, and the flag is never set while SCL stays high.
- R2: While low-timeout detection is enabled and SCL is low, the counter advances by one per system clock. With reload value R, the flag becomes visible after the 2^16 − R-th consecutive clock edge with SCL low. With R = 0xFFF0 this is the 16th edge, and with R = 0xFFFE it is the 2nd edge.
- R3: The low-timeout flag stays set until a clear strobe is sampled high. When an overflow and a clear strobe fall on the same edge, the flag stays set.
- R4: While low-timeout detection is disabled, the flag reads 0 and no flag is raised, however long SCL is low. The counter is reloaded, so counting restarts from the reload value once detection is enabled.
- R5: While free detection is enabled, the free event is a single-cycle pulse. It is visible right after the 11th clock-source tick sampled with both lines high, which is more than FREE_LIMIT = 10 ticks.
- R6: A low level on either SCL or SDA, sampled on any clock edge, restarts the free count from zero.
- R7: The free event fires once per idle interval. Further ticks while both lines stay high give no new event until a line has gone low.
- R8: While free detection is disabled, no free event occurs and the free count is cleared. After enabling, 11 ticks are needed again.
- R9: After reset, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| src_tick_i | input | 1 | One-cycle pulse per SMBus clock-source period |
| low_to_en_i | input | 1 | Enable for SCL-low timeout detection |
| free_to_en_i | input | 1 | Enable for bus-free detection |
| low_to_reload_i | input | 16 | Start value of the low-timeout counter |
| low_to_clr_i | input | 1 | Clear strobe for the low-timeout flag (write one to clear) |
| low_to_flag_o | output | 1 | Sticky low-timeout interrupt flag |
| free_stop_o | output | 1 | One-cycle bus-free event, to be treated as a STOP |

## Verification
The two functions that can meet on one clock edge are the overflow that sets the low-timeout flag and the clear strobe that resets it. The bench holds SCL low from a known reload value and raises the clear strobe exactly on the edge where the count wraps. A correct design must still show the flag set after that edge, and a later clear with no overflow must lower it. The two detectors cannot fire together, since the free event needs SCL high and the low timeout needs SCL low; the bench confirms that each stays quiet while the other is exercised.

// File: rtl/smbto_pkg.sv
package smbto_pkg;

   // State of the bus-free detector within one idle interval
   typedef enum logic {
      FD_COUNT = 1'b0,
      FD_FIRED = 1'b1
   } fd_state_e;

   localparam int unsigned DEF_RELOAD_W  = 16;
   localparam int unsigned DEF_FREE_TICK = 10;

endpackage

// File: rtl/smbto_low_timer.sv
module smbto_low_timer #(
   parameter int unsigned W        = 16,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         scl,
   input  logic [W-1:0] reload,
   input  logic         clr,
   output logic         flag
);

   localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

   if (W < 2) begin : g_bad_width
      $error("smbto_low_timer: W must be at least 2");
   end

   logic [W-1:0] cnt_q;
   logic         wrap;

   assign wrap = en && !scl && (cnt_q == ALL_ONES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!en || scl || wrap) begin
         cnt_q <= reload;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   if (SET_WINS) begin : g_set_wins
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    flag <= 1'b0;
         else if (!en)  flag <= 1'b0;
         else if (wrap) flag <= 1'b1;
         else if (clr)  flag <= 1'b0;
      end
   end else begin : g_clr_wins
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    flag <= 1'b0;
         else if (!en)  flag <= 1'b0;
         else if (clr)  flag <= 1'b0;
         else if (wrap) flag <= 1'b1;
      end
   end

   // R1
   flag_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> !$past(scl));

   // R3
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && en && !clr) |=> flag);

   // R4
   dis_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !flag);

endmodule

// File: rtl/smbto_free_detect.sv
module smbto_free_detect
   import smbto_pkg::*;
#(
   parameter int unsigned LIMIT = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic scl,
   input  logic sda,
   input  logic tick,
   output logic evt
);

   localparam int unsigned    CW  = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM = CW'(LIMIT);

   if (LIMIT < 1) begin : g_bad_limit
      $error("smbto_free_detect: LIMIT must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   fd_state_e     st_q;
   logic          idle;

   assign idle = en && scl && sda;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         st_q  <= FD_COUNT;
         evt   <= 1'b0;
      end else begin
         evt <= 1'b0;
         if (!idle) begin
            cnt_q <= '0;
            st_q  <= FD_COUNT;
         end else if (st_q == FD_COUNT && tick) begin
            if (cnt_q == LIM) begin
               evt  <= 1'b1;
               st_q <= FD_FIRED;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   // R5
   evt_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt |-> $past(en && scl && sda && tick));

   // R7
   evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> !evt);

   // R8
   evt_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !evt);

endmodule

// File: rtl/smbus_timeout_mon.sv
module smbus_timeout_mon #(
   parameter int unsigned RELOAD_W   = smbto_pkg::DEF_RELOAD_W,
   parameter int unsigned FREE_LIMIT = smbto_pkg::DEF_FREE_TICK,
   parameter bit          SET_WINS   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                scl_i,
   input  logic                sda_i,
   input  logic                src_tick_i,
   input  logic                low_to_en_i,
   input  logic                free_to_en_i,
   input  logic [RELOAD_W-1:0] low_to_reload_i,
   input  logic                low_to_clr_i,
   output logic                low_to_flag_o,
   output logic                free_stop_o
);

   smbto_low_timer #(
      .W        (RELOAD_W),
      .SET_WINS (SET_WINS)
   ) u_low (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (low_to_en_i),
      .scl    (scl_i),
      .reload (low_to_reload_i),
      .clr    (low_to_clr_i),
      .flag   (low_to_flag_o)
   );

   smbto_free_detect #(
      .LIMIT (FREE_LIMIT)
   ) u_free (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (free_to_en_i),
      .scl   (scl_i),
      .sda   (sda_i),
      .tick  (src_tick_i),
      .evt   (free_stop_o)
   );

   // R2
   low_needs_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_i && !low_to_flag_o) |=> !low_to_flag_o);

   // R6
   free_needs_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_i || !sda_i) |=> !free_stop_o);

endmodule

// File: tb/tb_smbus_timeout_mon.sv
module tb_smbus_timeout_mon;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        scl, sda, tick, low_en, free_en, clr;
   logic [15:0] reload;
   logic        flag, evt;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      string req;
      bit    is_evt;
      logic  exp;
   } item_t;

   item_t q[$];

   always #(CLK_P/2) clk = ~clk;

   smbus_timeout_mon dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .scl_i           (scl),
      .sda_i           (sda),
      .src_tick_i      (tick),
      .low_to_en_i     (low_en),
      .free_to_en_i    (free_en),
      .low_to_reload_i (reload),
      .low_to_clr_i    (clr),
      .low_to_flag_o   (flag),
      .free_stop_o     (evt)
   );

   // monitor: compares queued expectations away from the active edge
   always @(negedge clk) begin
      while (q.size() > 0) begin
         item_t it;
         logic  act;
         it  = q.pop_front();
         act = it.is_evt ? evt : flag;
         checks++;
         if (act !== it.exp) begin
            fails++;
            $display("FAIL %s: %s actual=%b expected=%b", it.req,
                     it.is_evt ? "free_stop_o" : "low_to_flag_o", act, it.exp);
         end
      end
   end

   function automatic void expect_out(string req, bit is_evt, logic exp);
      item_t it;
      it.req = req; it.is_evt = is_evt; it.exp = exp;
      q.push_back(it);
   endfunction

   task automatic clk_n(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic tick_run(string req, int n, int fire_at);
      for (int i = 1; i <= n; i++) begin
         tick = 1'b1;
         clk_n(1);
         expect_out(req, 1'b1, (i == fire_at));
         tick = 1'b0;
         clk_n(1);
         expect_out(req, 1'b1, 1'b0);
      end
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; scl = 1'b1; sda = 1'b1; tick = 1'b0;
      low_en = 1'b0; free_en = 1'b0; clr = 1'b0; reload = 16'hFFF0;
      clk_n(3);
      rst_n = 1'b1;
      clk_n(1);
      expect_out("R9", 1'b0, 1'b0);
      expect_out("R9", 1'b1, 1'b0);

      // R2: overflow after 16 low edges from 0xFFF0
      low_en = 1'b1;
      clk_n(2);
      scl = 1'b0;
      for (int i = 1; i <= 16; i++) begin
         clk_n(1);
         expect_out("R2", 1'b0, (i == 16));
      end

      // R3: clear with no overflow lowers the flag
      scl = 1'b1; clr = 1'b1;
      clk_n(1);
      clr = 1'b0;
      expect_out("R3", 1'b0, 1'b0);

      // R1: long high, and two short lows separated by high
      clk_n(100);
      expect_out("R1", 1'b0, 1'b0);
      scl = 1'b0; clk_n(10);
      scl = 1'b1; clk_n(1);
      scl = 1'b0; clk_n(10);
      expect_out("R1", 1'b0, 1'b0);
      scl = 1'b1; clk_n(1);

      // R3: clear on the overflow edge, set wins
      scl = 1'b0;
      clk_n(15);
      expect_out("R3", 1'b0, 1'b0);
      clr = 1'b1;
      clk_n(1);
      clr = 1'b0;
      expect_out("R3", 1'b0, 1'b1);
      scl = 1'b1;
      clk_n(5);
      expect_out("R3", 1'b0, 1'b1);

      // R4: disable clears and blocks the flag
      low_en = 1'b0;
      clk_n(1);
      expect_out("R4", 1'b0, 1'b0);
      scl = 1'b0;
      clk_n(40);
      expect_out("R4", 1'b0, 1'b0);
      reload = 16'hFFFE;
      clk_n(1);
      low_en = 1'b1;
      clk_n(1);
      expect_out("R4", 1'b0, 1'b0);
      clk_n(1);
      expect_out("R2", 1'b0, 1'b1);
      low_en = 1'b0; scl = 1'b1;
      clk_n(1);
      expect_out("R4", 1'b0, 1'b0);

      // R5: free event on the 11th tick
      free_en = 1'b1;
      clk_n(1);
      tick_run("R5", 11, 11);

      // R7: no repeat in the same idle interval
      tick_run("R7", 5, 0);

      // R6: SCL low restarts, then SDA low restarts
      scl = 1'b0; clk_n(1); scl = 1'b1;
      tick_run("R6", 6, 0);
      sda = 1'b0; clk_n(1); sda = 1'b1;
      tick_run("R6", 11, 11);

      // R8: disabled gives no event, re-enable needs 11 ticks
      free_en = 1'b0;
      sda = 1'b0; clk_n(1); sda = 1'b1;
      tick_run("R8", 15, 0);
      free_en = 1'b1;
      tick_run("R8", 11, 11);
      expect_out("R1", 1'b0, 1'b0);

      clk_n(2);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule